// File: doc/BRIEF.md
# Auto-Drain Queue Controller

The block holds a small first-in first-out queue of 4-bit words and decides who may move data through it. In the loading phase the user pushes words with a write enable. The moment the queue reports full, the block locks out the user. It then pops one word per fixed interval, oldest first, until the queue is empty. After that it hands control back to the user.

The interval comes from a cycle divider whose period is a parameter. It defaults to one second of a 100 MHz clock and can be made short for simulation. The divider is held cleared while loading, so a drain always starts with a complete interval. The most recently popped word is held on the data output between pops. Full and empty are brought out as status flags.

Top module: `auto_drain_fifo`

## Requirements
- R1: After reset, empty_o is 1, full_o is 0, data_o is 0, and the block is in the loading phase.
- R2: In the loading phase, a cycle with wr_en_i high stores data_i at the tail of the queue. empty_o drops after the first stored word, and full_o rises once DEPTH words are stored (16 by default).
- R3: While the queue holds fewer than DEPTH words, no word is ever popped, however long the block waits. data_o stays unchanged.
- R4: One clock after full_o is seen high, the block enters the draining phase. The first pop happens exactly TICK_CYCLES clocks after that, so data_o changes TICK_CYCLES+1 clock edges after the edge that stored the last word.
- R5: In the draining phase, words are popped oldest first, one every TICK_CYCLES clocks. data_o takes the popped word at the pop edge and holds it until the next pop.
- R6: Writes are ignored throughout the draining phase, including the cycle in which full_o is high.
- R7: After the last pop, empty_o is 1 and the block returns to the loading phase one clock later. A write presented in that clock is dropped, and writes are accepted from the next clock on.
- R8: full_o stays high until the first pop and is low after it.
- R9: The internal pop strobe is high for a single cycle per interval and never fires on an empty queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | User write request |
| data_i | input | 4 | Word to store |
| data_o | output | 4 | Last word popped during draining |
| full_o | output | 1 | Queue holds DEPTH words |
| empty_o | output | 1 | Queue holds no words |

## Verification
The bench checks the exact cycle of every pop. A divider that is not restarted on entry, or that is off by one, would shift data_o by one or more clocks. Either error is caught by sampling one clock before and one clock at each expected pop. Writes are held high through whole drains. A design that accepted them would end a drain with words left over, so empty_o would stay low. A write is placed in the hand-back clock after the last pop. If that write were accepted, the next load would show empty_o low at once and full_o a word early. One load pauses part-way for several intervals, which exposes a design that pops before full is reached.

// File: rtl/afd_pkg.sv
package afd_pkg;
  typedef enum logic {
    ST_LOAD  = 1'b0,
    ST_DRAIN = 1'b1
  } afd_state_e;
endpackage

// File: rtl/afd_tick_div.sv
module afd_tick_div #(
  parameter int unsigned PERIOD = 100_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int unsigned CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt_q;

  // held at zero while disabled so each enable starts a full period
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (!en_i)      cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                 cnt_q <= cnt_q + CW'(1);
  end

  assign tick_o = en_i && (cnt_q == LAST);

  a_r5_tick_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/afd_fifo.sv
module afd_fifo #(
  parameter int unsigned DATA_W = 4,
  parameter int unsigned DEPTH  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] head_o,
  output logic              full_o,
  output logic              empty_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [AW-1:0]     wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk_i) begin
    if (wr_i) mem_q[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (wr_i) wr_ptr_q <= (wr_ptr_q == PTR_LAST) ? '0 : wr_ptr_q + AW'(1);
      if (rd_i) rd_ptr_q <= (rd_ptr_q == PTR_LAST) ? '0 : rd_ptr_q + AW'(1);
      case ({wr_i, rd_i})
        2'b10:   cnt_q <= cnt_q + CNT_W'(1);
        2'b01:   cnt_q <= cnt_q - CNT_W'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign head_o  = mem_q[rd_ptr_q];
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);

  a_r6_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |-> !full_o);
  a_r9_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |-> !empty_o);
endmodule

// File: rtl/afd_ctrl.sv
module afd_ctrl
  import afd_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_req_i,
  input  logic full_i,
  input  logic empty_i,
  input  logic tick_i,
  output logic wr_o,
  output logic rd_o,
  output logic drain_o
);
  afd_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_LOAD:  if (full_i)  state_d = ST_DRAIN;
      ST_DRAIN: if (empty_i) state_d = ST_LOAD;
      default:  state_d = ST_LOAD;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_LOAD;
    else         state_q <= state_d;
  end

  assign drain_o = (state_q == ST_DRAIN);
  assign wr_o    = wr_req_i && !drain_o && !full_i;
  assign rd_o    = drain_o && tick_i && !empty_i;

  a_r4_enter_drain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!drain_o && full_i) |=> drain_o);
  a_r9_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_o |=> !rd_o);
  a_r3_no_pop_loading: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !drain_o |-> !tick_i);
endmodule

// File: rtl/auto_drain_fifo.sv
module auto_drain_fifo #(
  parameter int unsigned DATA_W      = 4,
  parameter int unsigned DEPTH       = 16,
  parameter int unsigned TICK_CYCLES = 100_000_000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              full_o,
  output logic              empty_o
);
  logic              wr_fire, rd_fire, drain, tick;
  logic [DATA_W-1:0] head;
  logic [DATA_W-1:0] out_q;

  afd_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_fire),
    .wdata_i (data_i),
    .rd_i    (rd_fire),
    .head_o  (head),
    .full_o  (full_o),
    .empty_o (empty_o)
  );

  afd_tick_div #(.PERIOD(TICK_CYCLES)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (drain),
    .tick_o (tick)
  );

  afd_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_req_i (wr_en_i),
    .full_i   (full_o),
    .empty_i  (empty_o),
    .tick_i   (tick),
    .wr_o     (wr_fire),
    .rd_o     (rd_fire),
    .drain_o  (drain)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      out_q <= '0;
    else if (rd_fire) out_q <= head;
  end

  assign data_o = out_q;

  a_r5_out_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_fire |=> $stable(data_o));
  a_r6_no_write_draining: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drain |-> !wr_fire);
endmodule

// File: tb/tb_auto_drain_fifo.sv
`timescale 1ns/1ps
module tb_auto_drain_fifo;
  localparam int N     = 5;
  localparam int DEPTH = 16;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] din = '0;
  logic [3:0] dout;
  logic       full, empty;
  int         total = 0, bad = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  auto_drain_fifo #(.DATA_W(4), .DEPTH(DEPTH), .TICK_CYCLES(N)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .data_i(din),
    .data_o(dout), .full_o(full), .empty_o(empty)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] pat(input int p, input int i);
    return 4'((i + 5 * p + 1) % 16);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [3:0] prev;
    prev = 4'h0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(empty == 1'b1, "R1 empty", int'(empty), 1);
    chk(full == 1'b0, "R1 full", int'(full), 0);
    chk(dout == 4'h0, "R1 data", int'(dout), 0);

    for (int p = 0; p < 4; p++) begin
      bit junk;
      junk = (p >= 2);
      for (int i = 0; i < DEPTH; i++) begin
        if (p == 1 && i == 10) begin
          wr_en = 1'b0;
          repeat (4 * N) @(negedge clk);
          chk(empty == 1'b0, "R3 empty", int'(empty), 0);
          chk(full == 1'b0, "R3 full", int'(full), 0);
          chk(dout == prev, "R3 no pop", int'(dout), int'(prev));
        end
        wr_en = 1'b1;
        din = pat(p, i);
        @(negedge clk);
        if (i == 0)  chk(empty == 1'b0, "R2 not empty", int'(empty), 0);
        // 15 words: full must still be low (R7: dropped hand-back write)
        if (i == DEPTH - 2) chk(full == 1'b0, "R2 R7 full early", int'(full), 0);
      end
      wr_en = junk;      // R6: write attempts while full and draining
      din = ~pat(p, 0);
      chk(full == 1'b1, "R2 full", int'(full), 1);
      chk(dout == prev, "R4 before drain", int'(dout), int'(prev));
      @(negedge clk);
      for (int k = 0; k < DEPTH; k++) begin
        repeat (N - 1) @(negedge clk);
        chk(dout == prev, (k == 0) ? "R4 early pop" : "R5 early pop", int'(dout), int'(prev));
        if (k == 0) chk(full == 1'b1, "R8 full held", int'(full), 1);
        @(negedge clk);
        chk(dout == pat(p, k), (k == 0) ? "R4 first pop" : "R5 pop data", int'(dout), int'(pat(p, k)));
        chk(full == 1'b0, "R8 full cleared", int'(full), 0);
        chk(empty == (k == DEPTH - 1), junk ? "R6 R7 empty" : "R7 empty", int'(empty),
            int'(k == DEPTH - 1));
        prev = pat(p, k);
      end
      wr_en = 1'b1;
      din = 4'hA;
      @(negedge clk);
      wr_en = 1'b0;
      chk(empty == 1'b1, "R7 hand-back write dropped", int'(empty), 1);
    end

    repeat (3 * N) @(negedge clk);
    chk(dout == prev, "R3 idle hold", int'(dout), int'(prev));
    chk(empty == 1'b1, "R3 idle empty", int'(empty), 1);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule